// File: doc/BRIEF.md
# Dual-Stream Compressed Elementary-Stream Output Port

This block hands compressed audio and video elementary-stream bytes to an external decoder over one shared data bus. Each stream arrives on its own valid/ready byte input. The decoder paces delivery with two active-low request lines, one per stream. The port moves a stream's data only while that stream's request is asserted. So the decoder alone sets the transfer rate.

A mode input chooses how bytes are delivered. In parallel mode a whole byte goes out in one clock. In serial mode a byte goes out one bit per clock on the bus's lowest lane, most significant bit first. Each stream has its own active-high strobe, so the decoder can tell whose data the bus holds. It captures that data on the rising clock edge. An upstream discontinuity pulse per stream marks that packets were lost. The next byte of that stream then goes out with the active-low error output asserted for that byte only. When both streams are requesting, the port takes them in turn at byte boundaries.

Top module: `es_out_port`

## Requirements
- R1: While in reset, and afterwards in every cycle with no strobe high, both strobes are low, `err_n` is high and `bus_data` is all zeros.
- R2: A stream's strobe is high in a cycle only if that stream's request input was low (active) in the cycle before.
- R3: Parallel mode: a byte accepted on a stream's input appears on all 8 bus lines in the next cycle, with that stream's strobe high for exactly that one cycle.
- R4: Serial mode: a byte goes out as 8 strobed bit-cycles on `bus_data[0]`, most significant bit first, with `bus_data[7:1]` held at zero.
- R5: Serial mode: a bit is sent only in a cycle after the owning stream's request was active; while it is inactive the byte pauses and resumes where it stopped. No other stream is served and no input byte is accepted until all 8 bits are out.
- R6: When both streams are eligible at a byte boundary, the stream not served by the previous transfer is chosen. Eligible means request active and input valid. A lone eligible stream is always chosen.
- R7: `aud_ready`/`vid_ready` is high only in the cycle a byte is taken, only while that stream's request is active and its valid is high, and never for both streams at once. Bytes of each stream leave in input order.
- R8: A pulse on `aud_disc`/`vid_disc` makes the next byte accepted afterwards on that stream go out with `err_n` low on all of its strobed cycles, and on no other cycle. A pulse in the same cycle as an acceptance applies to the following byte.
- R9: The mode input is sampled when a byte is accepted. A serial byte already in flight finishes serially after a switch to parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; the decoder captures on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_par | input | 1 | 1 = parallel byte transfers, 0 = serial bit transfers |
| aud_data | input | 8 | Audio byte input |
| aud_valid | input | 1 | Audio byte present |
| aud_ready | output | 1 | Audio byte taken this cycle |
| aud_disc | input | 1 | Pulse: discontinuity detected in the audio stream |
| vid_data | input | 8 | Video byte input |
| vid_valid | input | 1 | Video byte present |
| vid_ready | output | 1 | Video byte taken this cycle |
| vid_disc | input | 1 | Pulse: discontinuity detected in the video stream |
| aud_req_n | input | 1 | Decoder requests audio data (active low) |
| vid_req_n | input | 1 | Decoder requests video data (active low) |
| bus_data | output | 8 | Shared data bus to the decoder |
| aud_strobe | output | 1 | Bus holds valid audio data |
| vid_strobe | output | 1 | Bus holds valid video data |
| err_n | output | 1 | Active low: the strobed data follows a discontinuity |

## Verification
The hardest case to reach is a serial byte stalled partway through by its own request while the other stream requests and a discontinuity pulse arrives. The mode input may flip at the same time. Only then does the port show that it neither switches stream nor loses the pending error. The stimulus moves through phases in which each request line, each valid and each discontinuity input toggles at random with tuned rates. The last phase also flips the mode every few cycles. A behavioural reference model then predicts strobes, bus, error and ready on every clock.

// File: rtl/esop_pkg.sv
package esop_pkg;

  typedef enum logic {
    SRC_AUD = 1'b0,
    SRC_VID = 1'b1
  } src_e;

  // Turn-taking choice between two eligible streams
  function automatic src_e pick_src(input logic elig_a, input logic elig_v, input src_e last);
    if (elig_a && elig_v) return (last == SRC_AUD) ? SRC_VID : SRC_AUD;
    if (elig_a) return SRC_AUD;
    return SRC_VID;
  endfunction

  // One-hot strobe pattern {vid, aud} for a source
  function automatic logic [1:0] src_onehot(input src_e s);
    return (s == SRC_VID) ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/esop_disc_track.sv
module esop_disc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic disc_i,
  input  logic take_i,
  output logic pending_o
);

  logic pend_q;

  // A byte taken now carries the flag; a pulse in the same cycle waits for the next byte
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q & ~take_i) | disc_i;
  end

  assign pending_o = pend_q;

endmodule

// File: rtl/esop_arbiter.sv
module esop_arbiter
  import esop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] elig_i,
  input  logic       take_i,
  output src_e       grant_o
);

  src_e last_q;

  assign grant_o = pick_src(elig_i[0], elig_i[1], last_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= SRC_VID;
    else if (take_i) last_q <= grant_o;
  end

endmodule

// File: rtl/esop_shifter.sv
module esop_shifter
  import esop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              par_i,
  input  src_e              src_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              err_i,
  input  logic [1:0]        req_act_i,
  output logic              busy_o,
  output src_e              cur_src_o,
  output logic [DATA_W-1:0] bus_o,
  output logic [1:0]        stb_o,
  output logic              err_o,
  output logic              ser_o
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_LEFT = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL_LEFT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;
  src_e              cur_q;
  logic              cur_err_q;
  logic              step_ok;
  logic              cur_req;

  // Serial lane: one bit on lane 0, other lanes quiet
  function automatic logic [DATA_W-1:0] lane0(input logic b);
    return {{(DATA_W-1){1'b0}}, b};
  endfunction

  assign cur_req = (cur_q == SRC_VID) ? req_act_i[1] : req_act_i[0];
  assign step_ok = busy_q & cur_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      left_q    <= '0;
      busy_q    <= 1'b0;
      cur_q     <= SRC_AUD;
      cur_err_q <= 1'b0;
      bus_o     <= '0;
      stb_o     <= 2'b00;
      err_o     <= 1'b0;
      ser_o     <= 1'b0;
    end else begin
      bus_o <= '0;
      stb_o <= 2'b00;
      err_o <= 1'b0;
      ser_o <= 1'b0;
      if (load_i) begin
        stb_o <= src_onehot(src_i);
        err_o <= err_i;
        if (par_i) begin
          bus_o <= data_i;
        end else begin
          bus_o     <= lane0(data_i[DATA_W-1]);
          shreg_q   <= data_i << 1;
          left_q    <= FULL_LEFT;
          busy_q    <= 1'b1;
          cur_q     <= src_i;
          cur_err_q <= err_i;
          ser_o     <= 1'b1;
        end
      end else if (step_ok) begin
        bus_o   <= lane0(shreg_q[DATA_W-1]);
        shreg_q <= shreg_q << 1;
        left_q  <= left_q - 1'b1;
        if (left_q == LAST_LEFT) busy_q <= 1'b0;
        stb_o <= src_onehot(cur_q);
        err_o <= cur_err_q;
        ser_o <= 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign cur_src_o = cur_q;

endmodule

// File: rtl/es_out_port.sv
module es_out_port
  import esop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_par,
  input  logic [DATA_W-1:0] aud_data,
  input  logic              aud_valid,
  output logic              aud_ready,
  input  logic              aud_disc,
  input  logic [DATA_W-1:0] vid_data,
  input  logic              vid_valid,
  output logic              vid_ready,
  input  logic              vid_disc,
  input  logic              aud_req_n,
  input  logic              vid_req_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              aud_strobe,
  output logic              vid_strobe,
  output logic              err_n
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] req_act;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] take;
  logic [NUM_SRC-1:0] disc_in;
  logic [NUM_SRC-1:0] pend;
  logic [1:0]         stb;
  logic               load_en;
  logic               busy;
  logic               out_ser;
  logic               err_hi;
  logic               cur_is_vid;
  logic               load_err;
  logic [DATA_W-1:0]  load_data;
  src_e               grant;
  src_e               cur_src;

  assign req_act = {~vid_req_n, ~aud_req_n};
  assign elig    = req_act & {vid_valid, aud_valid};
  assign disc_in = {vid_disc, aud_disc};

  // A new byte is only taken at a byte boundary
  assign load_en = ~busy & (|elig);
  assign take    = load_en ? src_onehot(grant) : 2'b00;

  assign aud_ready = take[0];
  assign vid_ready = take[1];

  assign load_data = (grant == SRC_VID) ? vid_data : aud_data;
  assign load_err  = (grant == SRC_VID) ? pend[1] : pend[0];

  esop_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig_i  (elig),
    .take_i  (load_en),
    .grant_o (grant)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_disc
    esop_disc_track u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .disc_i    (disc_in[s]),
      .take_i    (take[s]),
      .pending_o (pend[s])
    );
  end

  esop_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_en),
    .par_i     (mode_par),
    .src_i     (grant),
    .data_i    (load_data),
    .err_i     (load_err),
    .req_act_i (req_act),
    .busy_o    (busy),
    .cur_src_o (cur_src),
    .bus_o     (bus_data),
    .stb_o     (stb),
    .err_o     (err_hi),
    .ser_o     (out_ser)
  );

  assign cur_is_vid = (cur_src == SRC_VID);
  assign aud_strobe = stb[0];
  assign vid_strobe = stb[1];
  assign err_n      = ~err_hi;

endmodule

// File: rtl/es_out_port_chk.sv
module es_out_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aud_req_n,
  input logic              vid_req_n,
  input logic              aud_valid,
  input logic              vid_valid,
  input logic              aud_ready,
  input logic              vid_ready,
  input logic              aud_strobe,
  input logic              vid_strobe,
  input logic              err_n,
  input logic [DATA_W-1:0] bus_data,
  input logic              out_ser,
  input logic              busy,
  input logic              cur_is_vid
);

  a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(aud_strobe || vid_strobe) |-> (bus_data == '0));

  a_r2_aud_paced: assert property (@(posedge clk) disable iff (!rst_n)
    aud_strobe |-> $past(!aud_req_n));

  a_r2_vid_paced: assert property (@(posedge clk) disable iff (!rst_n)
    vid_strobe |-> $past(!vid_req_n));

  a_r3_aud_take_shows: assert property (@(posedge clk) disable iff (!rst_n)
    aud_ready |=> aud_strobe);

  a_r3_vid_take_shows: assert property (@(posedge clk) disable iff (!rst_n)
    vid_ready |=> vid_strobe);

  a_r4_serial_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ser && (aud_strobe || vid_strobe)) |-> (bus_data[DATA_W-1:1] == '0));

  a_r5_hold_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_is_vid));

  a_r5_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(aud_ready || vid_ready));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aud_strobe, vid_strobe}));

  a_r7_one_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aud_ready, vid_ready}));

  a_r7_aud_take_legal: assert property (@(posedge clk) disable iff (!rst_n)
    aud_ready |-> (aud_valid && !aud_req_n));

  a_r7_vid_take_legal: assert property (@(posedge clk) disable iff (!rst_n)
    vid_ready |-> (vid_valid && !vid_req_n));

  a_r8_err_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> (aud_strobe || vid_strobe));

endmodule

bind es_out_port es_out_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .aud_req_n  (aud_req_n),
  .vid_req_n  (vid_req_n),
  .aud_valid  (aud_valid),
  .vid_valid  (vid_valid),
  .aud_ready  (aud_ready),
  .vid_ready  (vid_ready),
  .aud_strobe (aud_strobe),
  .vid_strobe (vid_strobe),
  .err_n      (err_n),
  .bus_data   (bus_data),
  .out_ser    (out_ser),
  .busy       (busy),
  .cur_is_vid (cur_is_vid)
);

// File: tb/es_out_port_bench.sv
`timescale 1ns/1ps
module es_out_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_par = 1'b1;
  logic [7:0] aud_data = '0, vid_data = '0;
  logic       aud_valid = 1'b0, vid_valid = 1'b0;
  logic       aud_disc = 1'b0, vid_disc = 1'b0;
  logic       aud_req_n = 1'b1, vid_req_n = 1'b1;
  logic       aud_ready, vid_ready;
  logic [7:0] bus_data;
  logic       aud_strobe, vid_strobe, err_n;

  always #2.5 clk = ~clk;

  es_out_port u_es_out_port (
    .clk(clk), .rst_n(rst_n), .mode_par(mode_par),
    .aud_data(aud_data), .aud_valid(aud_valid), .aud_ready(aud_ready), .aud_disc(aud_disc),
    .vid_data(vid_data), .vid_valid(vid_valid), .vid_ready(vid_ready), .vid_disc(vid_disc),
    .aud_req_n(aud_req_n), .vid_req_n(vid_req_n),
    .bus_data(bus_data), .aud_strobe(aud_strobe), .vid_strobe(vid_strobe), .err_n(err_n)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;
  string tag = "R1";

  // Source queues
  logic [7:0] qa[$];
  logic [7:0] qv[$];

  // Reference model state
  bit         m_busy = 0;
  int         m_left = 0;
  int         m_shift = 0;
  int         m_src = 0;
  bit         m_err = 0;
  int         m_last = 1;
  bit         m_pend[2] = '{0, 0};
  logic [7:0] exp_bus = '0;
  logic [1:0] exp_stb = '0;
  bit         exp_err = 0;
  int         err_bytes = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    check({vid_strobe, aud_strobe} === exp_stb, tag, "strobes", {vid_strobe, aud_strobe}, exp_stb);
    check(bus_data === exp_bus, tag, "bus", bus_data, exp_bus);
    check(err_n === ~exp_err, "R8", "err_n", err_n, ~exp_err);
  endtask

  // Predict the next cycle from the inputs just driven
  task automatic model_step();
    bit ra, rv, ea, ev, cur_req;
    int pop;
    logic [7:0] b;
    ra = !aud_req_n; rv = !vid_req_n;
    ea = ra && aud_valid; ev = rv && vid_valid;
    exp_bus = '0; exp_stb = '0; exp_err = 0;
    pop = -1;
    cur_req = (m_src == 1) ? rv : ra;
    if (!m_busy && (ea || ev)) begin
      pop = (ea && ev) ? 1 - m_last : (ea ? 0 : 1);
      m_last = pop;
      b = (pop == 1) ? qv[0] : qa[0];
      exp_err = m_pend[pop];
      if (exp_err) err_bytes++;
      exp_stb[pop] = 1'b1;
      if (mode_par) exp_bus = b;
      else begin
        exp_bus = {7'd0, b[7]};
        m_shift = b; m_left = 7; m_busy = 1; m_src = pop; m_err = exp_err;
      end
    end else if (m_busy && cur_req) begin
      exp_bus = {7'd0, m_shift[m_left-1]};
      m_left--;
      if (m_left == 0) m_busy = 0;
      exp_stb[m_src] = 1'b1;
      exp_err = m_err;
    end
    check(aud_ready === (pop == 0), "R7", "aud_ready", aud_ready, pop == 0);
    check(vid_ready === (pop == 1), "R7", "vid_ready", vid_ready, pop == 1);
    m_pend[0] = (m_pend[0] && pop != 0) || aud_disc;
    m_pend[1] = (m_pend[1] && pop != 1) || vid_disc;
    if (pop == 0) void'(qa.pop_front());
    if (pop == 1) void'(qv.pop_front());
  endtask

  // mode_sel: 0 serial, 1 parallel, 2 flipping
  task automatic run_phase(input string t, input int n, input int mode_sel,
                           input int req_pct, input int val_pct, input int disc_pct);
    tag = t;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_outputs();
      while (qa.size() < 3) qa.push_back(8'($urandom));
      while (qv.size() < 3) qv.push_back(8'($urandom));
      if (mode_sel == 2) begin
        if (($urandom % 6) == 0) mode_par = ~mode_par;
      end else mode_par = (mode_sel == 1);
      aud_req_n = !(($urandom % 100) < req_pct);
      vid_req_n = !(($urandom % 100) < req_pct);
      aud_valid = ($urandom % 100) < val_pct;
      vid_valid = ($urandom % 100) < val_pct;
      aud_data  = qa[0];
      vid_data  = qv[0];
      aud_disc  = ($urandom % 100) < disc_pct;
      vid_disc  = ($urandom % 100) < disc_pct;
      #1;
      model_step();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(aud_strobe === 1'b0 && vid_strobe === 1'b0, "R1", "strobes in reset", {vid_strobe, aud_strobe}, 0);
    check(err_n === 1'b1, "R1", "err_n in reset", err_n, 1);
    check(bus_data === 8'h00, "R1", "bus in reset", bus_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_outputs();
    // R3 R6: parallel, both always requesting -> strict turn-taking
    run_phase("R3 R6", 400, 1, 100, 100, 0);
    // R2 R8: parallel, sparse requests and data, discontinuity pulses
    run_phase("R2 R8", 1500, 1, 50, 70, 4);
    // R4 R6: serial, both always requesting
    run_phase("R4 R6", 800, 0, 100, 100, 2);
    // R5: serial with requests dropping mid-byte
    run_phase("R5", 2000, 0, 60, 80, 3);
    // R9: mode flips while serial bytes are in flight
    run_phase("R9", 2000, 2, 70, 85, 3);
    @(negedge clk);
    compare_outputs();
    check(err_bytes > 0, "R8", "error bytes seen", err_bytes, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule